// File: doc/BRIEF.md
# Banked GPIO Interrupt Aggregator

This block gathers the edge-status flags of a group of 32-pin GPIO register sets and turns them into interrupt request lines. In banked mode every 16 pins form one bank with its own level-sensitive request. A register set of 32 pins therefore feeds two banks: the lower half feeds an even bank and the upper half feeds the following odd bank. In direct mode the first few pins of the first register set each drive a request line of their own. A per-bank enable register gates both kinds of output.

The block also decodes the small address map around it. A single bank-enable register sits at byte offset 0x08. The register-set windows begin at 0x10 and repeat every 0x28 bytes, with at most five sets. For an access that falls in a window, the block raises that set's read or write strobe, hands on the offset inside the window and the write data, and returns that set's read data. The register sets live outside this block. Their status flags arrive as one vector indexed by pin number, so pin p sits at set p/32, bit p mod 32, and belongs to bank p/16.

The mode is a static configuration input. Request outputs are registered, so each one follows its inputs one clock later. Bus reads are combinational.

Top module: `gpio_bank_irq_agg`

## Requirements
- R1: A write to byte address 0x08 loads bits [NUM_BANKS-1:0] of the write data into the bank-enable register. A read of 0x08 returns that register in the low bits, with all higher bits zero.
- R2: An address in the window [0x10+0x28*k, 0x10+0x28*(k+1)), for a set k below NUM_SETS, raises bit k of the set read strobe or the set write strobe for a read or a write. `set_off` then equals the address minus the window base, and the read data equals word k of `set_rdata`.
- R3: At an address that is neither 0x08 nor inside a set window, reads return zero. Writes at such an address leave the bank-enable register unchanged and raise no set strobe.
- R4: In banked mode, `bank_irq[b]` one cycle later equals enable bit b ANDed with the OR of status bits [16*b+15:16*b]. For even b these are the low 16 bits of set b/2, and for odd b they are the high 16 bits.
- R5: A bank request is a level. It stays high on every cycle while any of its status bits is set and its enable bit is set. It falls one cycle after the last of those status bits clears.
- R6: Clearing an enable bit only masks its bank. When the bit is set again while the status is still present, the request returns on the next cycle.
- R7: In direct mode, `pin_irq[i]` one cycle later equals status bit i of set 0 ANDed with enable bit i/16, for i below DIRECT_PINS.
- R8: Outputs that are unused in the selected mode stay low: `pin_irq` in banked mode, and `bank_irq` in direct mode.
- R9: While reset is held, the enable register clears and all request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| direct_mode | input | 1 | Static mode select: 1 selects per-pin requests, 0 selects banked requests |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| set_we | output | NUM_SETS | Write strobe for each register set |
| set_re | output | NUM_SETS | Read strobe for each register set |
| set_off | output | 6 | Byte offset inside the selected set window |
| set_wdata | output | 32 | Write data passed on to the sets |
| set_rdata | input | 32*NUM_SETS | Read data of each set, with set k in word k |
| pin_status | input | 32*NUM_SETS | Edge-status flags indexed by pin number |
| bank_irq | output | NUM_BANKS | Banked level requests |
| pin_irq | output | DIRECT_PINS | Direct per-pin requests |

## Verification
Single status bits are placed on the first pin, on a pin in the upper half of set 0 and on pins in the second set. A mistake between low and high halves, or in the set-to-bank numbering, then lights the wrong line. Several bits are set together in one bank and then cleared one at a time, which separates a level output from a pulse or a single-bit tap. Enable bits are toggled while the status is held, which shows that masking and status are kept apart. In direct mode, pins on both sides of the 16-pin enable boundary and pins beyond the direct range tell correct gating from gating by the wrong enable bit.

// File: rtl/gia_pkg.sv
// Shared constants and helpers for the banked GPIO interrupt aggregator.
// Assumes byte addressing and 32-pin register sets split into 16-pin banks.
package gia_pkg;
    localparam int PINS_PER_SET  = 32;
    localparam int PINS_PER_BANK = 16;
    localparam int MAX_SETS      = 5;
    localparam int EN_OFFSET     = 8;    // bank-enable register byte address
    localparam int SET_BASE      = 16;   // first set window start
    localparam int SET_STRIDE    = 40;   // window spacing in bytes
    localparam int WORD_W        = 32;
    localparam int OFF_W         = 6;    // holds 0 .. SET_STRIDE-1

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
endpackage

// File: rtl/gia_addr_decode.sv
// Address decoder: recognises the bank-enable register and the set windows.
// Assumes the windows are disjoint and lie above the enable register.
module gia_addr_decode
    import gia_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                en_hit,
    output logic [NUM_SETS-1:0] set_sel,
    output logic [OFF_W-1:0]    set_off
);
    logic [31:0] addr_ext;

    assign addr_ext = 32'(addr);
    assign en_hit   = (addr_ext == 32'(EN_OFFSET));

    // One window comparator per register set
    generate
        for (genvar k = 0; k < NUM_SETS; k++) begin : g_win
            localparam logic [31:0] LO = 32'(SET_BASE + k * SET_STRIDE);
            localparam logic [31:0] HI = 32'(SET_BASE + (k + 1) * SET_STRIDE);
            assign set_sel[k] = (addr_ext >= LO) && (addr_ext < HI);
        end
    endgenerate

    // Offset inside whichever window matched
    always_comb begin
        set_off = '0;
        for (int k = 0; k < NUM_SETS; k++) begin
            if (set_sel[k]) begin
                set_off = OFF_W'(addr_ext - 32'(SET_BASE + k * SET_STRIDE));
            end
        end
    end

    // Decoded targets never overlap
    always_comb begin
        if (!$isunknown(addr)) begin
            AST_WINDOW_EXCL: assert ($onehot0(set_sel)); // R2
            AST_EN_NOT_IN_WINDOW: assert (!(en_hit && (|set_sel))); // R3
        end
    end
endmodule

// File: rtl/gia_bank_merge.sv
// Banked request merge: one registered level request per 16-pin bank.
// Assumes status is indexed by pin number, so bank b owns bits [16b+15:16b].
module gia_bank_merge
    import gia_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               banked_on,
    input  logic [NUM_BANKS-1:0]               en,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] status,
    output logic [NUM_BANKS-1:0]               irq_o
);
    logic [NUM_BANKS-1:0] raw;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            // Any pending bit of this bank, gated by mode and enable
            assign raw[b] = banked_on && en[b] && (|status[b*PINS_PER_BANK +: PINS_PER_BANK]);

            AST_MASK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                !en[b] |=> !irq_o[b]); // R6
            AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (banked_on && en[b] && (|status[b*PINS_PER_BANK +: PINS_PER_BANK])) |=> irq_o[b]); // R5
        end
    endgenerate

    // Register the requests
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= '0;
        else        irq_o <= raw;
    end
endmodule

// File: rtl/gia_direct_route.sv
// Direct request routing: the first DIRECT_PINS pins of set 0 each get a line.
// Assumes pin i is gated by bank-enable bit i/16.
module gia_direct_route
    import gia_pkg::*;
#(
    parameter int DIRECT_PINS = 20,
    parameter int EN_USED     = ceil_div(DIRECT_PINS, PINS_PER_BANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   direct_on,
    input  logic [EN_USED-1:0]     en,
    input  logic [DIRECT_PINS-1:0] status0,
    output logic [DIRECT_PINS-1:0] pin_irq_o
);
    logic [DIRECT_PINS-1:0] raw;

    generate
        for (genvar i = 0; i < DIRECT_PINS; i++) begin : g_pin
            // Each pin gated by the enable of the 16-pin group it sits in
            assign raw[i] = direct_on && en[i / PINS_PER_BANK] && status0[i];
        end
    endgenerate

    // Register the per-pin requests
    always_ff @(posedge clk) begin
        if (!rst_n) pin_irq_o <= '0;
        else        pin_irq_o <= raw;
    end

    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_on && en[0] && status0[0]) |=> pin_irq_o[0]); // R7
endmodule

// File: rtl/gpio_bank_irq_agg.sv
// Top level: bank-enable register, address map and request generation.
// Assumes direct_mode is static and NUM_PINS needs at most five sets.
module gpio_bank_irq_agg
    import gia_pkg::*;
#(
    parameter int NUM_PINS    = 64,
    parameter int DIRECT_PINS = 20,
    parameter int ADDR_W      = 8,
    localparam int NUM_SETS   = (NUM_PINS + 31) / 32,
    localparam int NUM_BANKS  = (NUM_PINS + 15) / 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         direct_mode,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic [NUM_SETS-1:0]          set_we,
    output logic [NUM_SETS-1:0]          set_re,
    output logic [5:0]                   set_off,
    output logic [31:0]                  set_wdata,
    input  logic [32*NUM_SETS-1:0]       set_rdata,
    input  logic [32*NUM_SETS-1:0]       pin_status,
    output logic [NUM_BANKS-1:0]         bank_irq,
    output logic [DIRECT_PINS-1:0]       pin_irq
);
    localparam int EN_USED = ceil_div(DIRECT_PINS, PINS_PER_BANK);

    logic                 en_hit;
    logic [NUM_SETS-1:0]  set_sel;
    logic [NUM_BANKS-1:0] en_q;

    gia_addr_decode #(.NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .en_hit  (en_hit),
        .set_sel (set_sel),
        .set_off (set_off)
    );

    // Strobes and write data towards the register sets
    assign set_we    = set_sel & {NUM_SETS{bus_wr}};
    assign set_re    = set_sel & {NUM_SETS{bus_rd}};
    assign set_wdata = bus_wdata;

    // Bank-enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                en_q <= '0;
        else if (bus_wr && en_hit) en_q <= bus_wdata[NUM_BANKS-1:0];
    end

    // Read mux: enable register, selected set, or zero
    always_comb begin
        bus_rdata = '0;
        if (en_hit) bus_rdata = 32'(en_q);
        for (int k = 0; k < NUM_SETS; k++) begin
            if (set_sel[k]) bus_rdata = set_rdata[k*WORD_W +: WORD_W];
        end
    end

    gia_bank_merge #(.NUM_BANKS(NUM_BANKS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .banked_on (!direct_mode),
        .en        (en_q),
        .status    (pin_status[NUM_BANKS*PINS_PER_BANK-1:0]),
        .irq_o     (bank_irq)
    );

    gia_direct_route #(.DIRECT_PINS(DIRECT_PINS)) u_direct (
        .clk       (clk),
        .rst_n     (rst_n),
        .direct_on (direct_mode),
        .en        (en_q[EN_USED-1:0]),
        .status0   (pin_status[DIRECT_PINS-1:0]),
        .pin_irq_o (pin_irq)
    );

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(EN_OFFSET)) |=> en_q == $past(bus_wdata[NUM_BANKS-1:0])); // R1
    AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADDR_W'(EN_OFFSET)) |=> $stable(en_q)); // R3
    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode |=> bank_irq == '0); // R8
    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !direct_mode |=> pin_irq == '0); // R8
endmodule

// File: tb/gpio_bank_irq_agg_bench.sv
`timescale 1ns/1ps
module gpio_bank_irq_agg_bench;
    localparam int NP = 64;
    localparam int DP = 20;
    localparam int NS = 2;
    localparam int NB = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           direct_mode = 1'b0;
    logic [7:0]     bus_addr = 8'h00;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NS-1:0]  set_we, set_re;
    logic [5:0]     set_off;
    logic [31:0]    set_wdata;
    logic [63:0]    set_rdata = {32'hC0DE_0001, 32'hBEEF_0000};
    logic [63:0]    pin_status = '0;
    logic [NB-1:0]  bank_irq;
    logic [DP-1:0]  pin_irq;

    gpio_bank_irq_agg #(.NUM_PINS(NP), .DIRECT_PINS(DP), .ADDR_W(8)) u_gpio_bank_irq_agg (
        .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .set_we(set_we), .set_re(set_re), .set_off(set_off),
        .set_wdata(set_wdata), .set_rdata(set_rdata),
        .pin_status(pin_status), .bank_irq(bank_irq), .pin_irq(pin_irq)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit started = 0;
    string irq_tag = "R4";

    // Reference state
    logic [NB-1:0] m_en = '0;
    logic [NB-1:0] m_bank = '0;
    logic [DP-1:0] m_pin = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int win_of(input logic [7:0] a);
        for (int k = 0; k < NS; k++)
            if (int'(a) >= 16 + 40 * k && int'(a) < 56 + 40 * k) return k;
        return -1;
    endfunction

    // Behavioural model, evaluated at each rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_en = '0; m_bank = '0; m_pin = '0;
        end else begin
            for (int b = 0; b < NB; b++)
                m_bank[b] = !direct_mode && m_en[b] && (pin_status[16*b +: 16] != 16'h0);
            for (int i = 0; i < DP; i++)
                m_pin[i] = direct_mode && m_en[i/16] && pin_status[i];
            if (bus_wr && bus_addr == 8'h08) m_en = bus_wdata[NB-1:0];
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (started) begin
            int w;
            logic [31:0] exp_rd;
            logic [NS-1:0] exp_sel;
            string atag;
            w = win_of(bus_addr);
            exp_sel = '0;
            if (w >= 0) exp_sel[w] = 1'b1;
            if (bus_addr == 8'h08) begin exp_rd = 32'(m_en); atag = "R1"; end
            else if (w >= 0) begin exp_rd = set_rdata[32*w +: 32]; atag = "R2"; end
            else begin exp_rd = 32'h0; atag = "R3"; end
            if (!rst_n) begin
                chk("R9", 64'(bank_irq), 64'(0));
                chk("R9", 64'(pin_irq), 64'(0));
            end else begin
                chk(direct_mode ? "R8" : irq_tag, 64'(bank_irq), 64'(m_bank));
                chk(direct_mode ? "R7" : "R8", 64'(pin_irq), 64'(m_pin));
            end
            chk(atag, 64'(bus_rdata), 64'(exp_rd));
            chk(w >= 0 ? "R2" : "R3", 64'(set_we), 64'(exp_sel & {NS{bus_wr}}));
            chk(w >= 0 ? "R2" : "R3", 64'(set_re), 64'(exp_sel & {NS{bus_rd}}));
            if (w >= 0) chk("R2", 64'(set_off), 64'(int'(bus_addr) - 16 - 40 * w));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_fail++;
            $display("watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
    endtask

    initial begin
        // R9: reset with status pending
        pin_status = 64'hFFFF_FFFF_FFFF_FFFF;
        tick(3);
        rst_n = 1'b1;
        pin_status = '0;
        tick();
        // R1: enable readback, upper bits zero
        rd(8'h08);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08);
        wr(8'h08, 32'h0000_0005);
        rd(8'h08);
        wr(8'h08, 32'h0000_000F);
        // R4: single pins in each half of each set
        irq_tag = "R4";
        pin_status = 64'h1;                 tick(2);
        pin_status = 64'h1 << 17;           tick(2);
        pin_status = 64'h1 << 40;           tick(2);
        pin_status = 64'h1 << 63;           tick(2);
        pin_status = 64'h0001_8000_0000_8001; tick(2);
        pin_status = '0;                    tick(2);
        // R5: level held while bits remain
        irq_tag = "R5";
        pin_status = (64'h1 << 20) | (64'h1 << 25); tick(3);
        pin_status = 64'h1 << 25;           tick(3);
        pin_status = '0;                    tick(2);
        // R6: mask then unmask with status held
        irq_tag = "R6";
        pin_status = (64'h1 << 20) | (64'h1 << 50);
        tick(2);
        wr(8'h08, 32'h0000_0005);
        tick(2);
        wr(8'h08, 32'h0000_000F);
        tick(2);
        pin_status = '0;
        irq_tag = "R4";
        tick(2);
        // R3: stray writes and reads
        set_rdata = {32'h1234_5678, 32'h9ABC_DEF0};
        wr(8'h00, 32'h0);
        wr(8'h09, 32'h0);
        wr(8'h0C, 32'h0);
        wr(8'h60, 32'h0);
        wr(8'hFF, 32'h0);
        rd(8'h08);
        rd(8'h04);
        rd(8'h60);
        rd(8'h0F);
        // R2: window edges of both sets
        rd(8'h10); rd(8'h37); rd(8'h38); rd(8'h5F); rd(8'h24);
        wr(8'h10, 32'hAAAA_5555);
        wr(8'h5F, 32'h5555_AAAA);
        // R7 and R8: direct mode
        direct_mode = 1'b1;
        wr(8'h08, 32'h0000_0001);
        pin_status = (64'h1 << 0) | (64'h1 << 5) | (64'h1 << 19) | (64'h1 << 22) | (64'h1 << 40);
        tick(3);
        wr(8'h08, 32'h0000_0002);
        tick(2);
        wr(8'h08, 32'h0000_0003);
        tick(2);
        pin_status = 64'h1 << 15;
        tick(2);
        pin_status = 64'h1 << 16;
        tick(2);
        pin_status = '0;
        tick(2);
        // R8: back to banked, pin lines low
        direct_mode = 1'b0;
        wr(8'h08, 32'h0000_000F);
        pin_status = 64'h0000_0000_000F_0003;
        tick(3);
        pin_status = '0;
        tick(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule